// File: doc/BRIEF.md
# Descriptor Ring Tail Post Engine

This block holds the pointer state for a set of egress descriptor rings (64 by default) that a DMA fetcher serves. Software posts work with one memory-mapped store. The store carries the tail index as it was before the post, the number of contiguous descriptors being added and the generation of that tail. The engine works out the new tail modulo the ring size and carries a generation flip into the tail when the post crosses the wrap point. For each ring it raises a fetch request while descriptors are outstanding. Each completion reported by the fetcher advances the ring's head and adds one to a rolling count of finished descriptors.

A load from the same region returns, one cycle later, the head, the rolling count and the head's generation. Valid descriptors carry the inverse of that generation. A post with a count of zero is a wake-up: it forces the ring to request a fetch even when the pointers say the ring is empty. A per-ring flush bit suppresses fetching, and clearing that bit resets the ring's count. Each ring's size is a power of two, set through a configuration port.

None of the stream-like ports apply back-pressure. A store, load, completion, configuration or flush write is taken in the cycle its valid is high. Load responses always arrive exactly one cycle after an accepted load.

Top module: `ring_post_engine`

## Requirements
- R1: After reset every ring has head 0, tail 0, both generations 0, count 0, flush clear, no pending wake and a size of 2^RST_LOG2 (16 by default). No fetch request is raised.
- R2: A store whose address bits [28:26] equal 5 targets the ring selected by address bits [8:3]. The data word holds the old tail in bits [15:0], the count in bits [31:16] and the tail generation in bit 32. The new tail is (old tail masked to the ring size + count) modulo the ring size.
- R3: A store or load whose address bits [28:26] are not 5 is ignored. A store changes no fetch request. A load produces no response.
- R4: A single post may cover the full ring size. A post of the full size at the head keeps the ring requesting until exactly that many completions have arrived.
- R5: A post with count 0 sets a wake flag. The ring raises its fetch request while the flag is set, even with head equal to tail. The next completion on that ring clears the flag. A completion on a ring with no outstanding descriptors leaves head, generation and count unchanged.
- R6: A completion on a ring with outstanding descriptors advances its head by one modulo the size and adds one to its count modulo 2^16. A region-5 load returns, in the following cycle, the head in bits [15:0], the count in bits [31:16] and the head generation in bit 32.
- R7: The head generation flips each time the head wraps from size-1 to 0.
- R8: While a ring's flush bit is set, its fetch request is low. Writing the bit to 0 while it is set clears that ring's count.
- R9: The configuration port sets a ring's size to 2^log2. Index bits at or above log2 in a post are ignored.
- R10: When old tail + count reaches or passes the ring size, the stored tail generation is the posted generation inverted. Outstanding work is judged on head and tail together with their generations. The fetch request is high exactly when the ring is not flushed and either the pointers or generations differ or a wake is pending.
- R11: Rings are independent: operations on one ring change no other ring's request or load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Memory-mapped store strobe |
| st_addr | input | 29 | Store address: region [28:26], ring [8:3] |
| st_data | input | IDX_W+CNT_W+1 | Old tail, count, tail generation |
| ld_valid | input | 1 | Memory-mapped load strobe |
| ld_addr | input | 29 | Load address, same layout as stores |
| ld_resp_valid | output | 1 | Load response strobe, one cycle after a hit |
| ld_resp_data | output | IDX_W+CNT_W+1 | Head, rolling count, head generation |
| cfg_valid | input | 1 | Ring size write strobe |
| cfg_ring | input | 6 | Ring whose size is written |
| cfg_log2 | input | $clog2(IDX_W) | log2 of the ring size |
| flush_valid | input | 1 | Flush bit write strobe |
| flush_ring | input | 6 | Ring whose flush bit is written |
| flush_val | input | 1 | New flush bit value |
| cmpl_valid | input | 1 | Fetcher completion strobe |
| cmpl_ring | input | 6 | Ring that finished one descriptor |
| fetch_req | output | NUM_RINGS | Per-ring fetch request |

## Verification
The bench sweeps one ring through sizes 2, 4 and 8. For every count from zero to the full size, it posts at the current tail and counts the completions needed to drain the ring. A design that dropped the wrap carry would see a full-size post as no work at all. A design that let an empty completion move the head would drift off the tail after every wake-up. Posts across the wrap point check that the head generation flips exactly once per lap. Further cases cover index bits above the ring size, flushing with a count reset, wrong-region stores and loads, and a whole-vector compare of the other rings' requests, which would expose a ring decode that leaks into a neighbour.

// File: rtl/ring_post_pkg.sv
package ring_post_pkg;
  // Memory-mapped address layout shared by stores and loads.
  localparam int unsigned ADDR_W      = 29;
  localparam int unsigned REGION_LSB  = 26;
  localparam int unsigned REGION_W    = 3;
  localparam int unsigned REGION_CODE = 5;
  localparam int unsigned RSEL_LSB    = 3;
  localparam int unsigned RSEL_W      = 6;
endpackage

// File: rtl/ring_post_decode.sv
module ring_post_decode
  import ring_post_pkg::*;
#(
  parameter int NUM_RINGS = 64
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [RSEL_W-1:0] ring
);
  logic [REGION_W-1:0] region;
  logic                in_range;

  assign region = addr[REGION_LSB +: REGION_W];
  assign ring   = addr[RSEL_LSB +: RSEL_W];

  generate
    if (NUM_RINGS < (1 << RSEL_W)) begin : g_limited
      assign in_range = (32'(ring) < NUM_RINGS);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign hit = req && (region == REGION_W'(REGION_CODE)) && in_range;
endmodule

// File: rtl/ring_ptr_slot.sv
module ring_ptr_slot #(
  parameter int IDX_W    = 16,
  parameter int CNT_W    = 16,
  parameter int LOG_W    = 4,
  parameter int RST_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_en,
  input  logic [IDX_W-1:0] post_idx,
  input  logic [CNT_W-1:0] post_cnt,
  input  logic             post_gen,
  input  logic             cmpl_en,
  input  logic             cfg_en,
  input  logic [LOG_W-1:0] cfg_log2,
  input  logic             flush_en,
  input  logic             flush_val,
  output logic [IDX_W-1:0] head_o,
  output logic             gen_o,
  output logic [CNT_W-1:0] done_o,
  output logic             fetch_req_o
);
  localparam int SUM_W = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

  logic [LOG_W-1:0] log2_q;
  logic [IDX_W-1:0] head_q, tail_q, mask;
  logic             hgen_q, tgen_q, wake_q, flush_q;
  logic [CNT_W-1:0] done_q;
  logic [SUM_W-1:0] sum;
  logic             ptr_pend, post_wrap, head_wrap, flush_drop;
  logic [IDX_W-1:0] tail_nxt;

  assign mask      = ~({IDX_W{1'b1}} << log2_q);
  assign sum       = SUM_W'(post_idx & mask) + SUM_W'(post_cnt);
  assign post_wrap = sum[log2_q];
  assign tail_nxt  = IDX_W'(sum) & mask;
  assign ptr_pend  = (head_q != tail_q) || (hgen_q != tgen_q);
  assign head_wrap = (head_q == mask);
  assign flush_drop = flush_en && flush_q && !flush_val;

  // Tail side: written only by posts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      tgen_q <= 1'b0;
    end else if (post_en) begin
      tail_q <= tail_nxt;
      tgen_q <= post_gen ^ post_wrap;
    end
  end

  // Head side: advanced by completions while work is outstanding.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      hgen_q <= 1'b0;
    end else if (cmpl_en && ptr_pend) begin
      head_q <= (head_q + IDX_W'(1)) & mask;
      if (head_wrap) hgen_q <= ~hgen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else if (flush_drop) begin
      done_q <= '0;
    end else if (cmpl_en && ptr_pend) begin
      done_q <= done_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
    end else if (post_en && (post_cnt == '0)) begin
      wake_q <= 1'b1;
    end else if (cmpl_en) begin
      wake_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      log2_q  <= LOG_W'(RST_LOG2);
    end else begin
      if (flush_en) flush_q <= flush_val;
      if (cfg_en)   log2_q  <= cfg_log2;
    end
  end

  assign head_o      = head_q;
  assign gen_o       = hgen_q;
  assign done_o      = done_q;
  assign fetch_req_o = !flush_q && (ptr_pend || wake_q);

  // An empty completion leaves the head side untouched.
  assert_empty_cmpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_en && !ptr_pend) |=> ($stable(head_q) && $stable(hgen_q)));

  assert_wake_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !flush_q) |-> fetch_req_o);

  assert_gen_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_en && ptr_pend && head_wrap) |=> (hgen_q != $past(hgen_q)) && (head_q == '0));

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_drop |=> (done_q == '0));

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !fetch_req_o);
endmodule

// File: rtl/ring_post_engine.sv
module ring_post_engine
  import ring_post_pkg::*;
#(
  parameter int  NUM_RINGS = 64,
  parameter int  IDX_W     = 16,
  parameter int  CNT_W     = 16,
  parameter int  RST_LOG2  = 4,
  localparam int LOG_W     = $clog2(IDX_W),
  localparam int DATA_W    = IDX_W + CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [DATA_W-1:0]    st_data,
  input  logic                 ld_valid,
  input  logic [ADDR_W-1:0]    ld_addr,
  output logic                 ld_resp_valid,
  output logic [DATA_W-1:0]    ld_resp_data,
  input  logic                 cfg_valid,
  input  logic [RSEL_W-1:0]    cfg_ring,
  input  logic [LOG_W-1:0]     cfg_log2,
  input  logic                 flush_valid,
  input  logic [RSEL_W-1:0]    flush_ring,
  input  logic                 flush_val,
  input  logic                 cmpl_valid,
  input  logic [RSEL_W-1:0]    cmpl_ring,
  output logic [NUM_RINGS-1:0] fetch_req
);
  logic              st_hit, ld_hit;
  logic [RSEL_W-1:0] st_ring, ld_ring;
  logic [IDX_W-1:0]  post_idx;
  logic [CNT_W-1:0]  post_cnt;
  logic              post_gen;

  logic [IDX_W-1:0]  head_a [NUM_RINGS];
  logic              gen_a  [NUM_RINGS];
  logic [CNT_W-1:0]  done_a [NUM_RINGS];
  logic [DATA_W-1:0] ld_word;

  assign post_idx = st_data[IDX_W-1:0];
  assign post_cnt = st_data[IDX_W +: CNT_W];
  assign post_gen = st_data[IDX_W+CNT_W];

  ring_post_decode #(.NUM_RINGS(NUM_RINGS)) u_st_dec (
    .req(st_valid), .addr(st_addr), .hit(st_hit), .ring(st_ring)
  );

  ring_post_decode #(.NUM_RINGS(NUM_RINGS)) u_ld_dec (
    .req(ld_valid), .addr(ld_addr), .hit(ld_hit), .ring(ld_ring)
  );

  generate
    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
      ring_ptr_slot #(
        .IDX_W(IDX_W), .CNT_W(CNT_W), .LOG_W(LOG_W), .RST_LOG2(RST_LOG2)
      ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_en    (st_hit && (st_ring == RSEL_W'(g))),
        .post_idx   (post_idx),
        .post_cnt   (post_cnt),
        .post_gen   (post_gen),
        .cmpl_en    (cmpl_valid && (cmpl_ring == RSEL_W'(g))),
        .cfg_en     (cfg_valid && (cfg_ring == RSEL_W'(g))),
        .cfg_log2   (cfg_log2),
        .flush_en   (flush_valid && (flush_ring == RSEL_W'(g))),
        .flush_val  (flush_val),
        .head_o     (head_a[g]),
        .gen_o      (gen_a[g]),
        .done_o     (done_a[g]),
        .fetch_req_o(fetch_req[g])
      );
    end
  endgenerate

  always_comb begin
    ld_word = '0;
    for (int i = 0; i < NUM_RINGS; i++) begin
      if (ld_ring == RSEL_W'(i)) ld_word = {gen_a[i], done_a[i], head_a[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_resp_valid <= 1'b0;
      ld_resp_data  <= '0;
    end else begin
      ld_resp_valid <= ld_hit;
      if (ld_hit) ld_resp_data <= ld_word;
    end
  end

  assert_resp_follows_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_resp_valid |-> $past(ld_valid));

  assert_foreign_store_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_hit && !cmpl_valid && !flush_valid && !cfg_valid) |=> $stable(fetch_req));
endmodule

// File: tb/ring_post_engine_tb.sv
module ring_post_engine_tb;
  localparam int NR     = 64;
  localparam int IW     = 16;
  localparam int CW     = 16;
  localparam int LW     = $clog2(IW);
  localparam int DW     = IW + CW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0, ld_valid = 1'b0;
  logic [28:0]   st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          ld_resp_valid;
  logic [DW-1:0] ld_resp_data;
  logic          cfg_valid = 1'b0, flush_valid = 1'b0, flush_val = 1'b0, cmpl_valid = 1'b0;
  logic [5:0]    cfg_ring = '0, flush_ring = '0, cmpl_ring = '0;
  logic [LW-1:0] cfg_log2 = '0;
  logic [NR-1:0] fetch_req;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  int m_head [NR];
  int m_tail [NR];
  int m_cnt  [NR];
  int m_log  [NR];
  bit m_hg   [NR];
  bit m_tg   [NR];
  bit m_wake [NR];
  bit m_fl   [NR];

  always #5 clk = ~clk;

  ring_post_engine #(.NUM_RINGS(NR), .IDX_W(IW), .CNT_W(CW), .RST_LOG2(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_resp_valid(ld_resp_valid), .ld_resp_data(ld_resp_data),
    .cfg_valid(cfg_valid), .cfg_ring(cfg_ring), .cfg_log2(cfg_log2),
    .flush_valid(flush_valid), .flush_ring(flush_ring), .flush_val(flush_val),
    .cmpl_valid(cmpl_valid), .cmpl_ring(cmpl_ring),
    .fetch_req(fetch_req)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int msk(int r);
    return (1 << m_log[r]) - 1;
  endfunction

  function automatic logic [28:0] mkaddr(int r, int region);
    return 29'((region << 26) | (r << 3));
  endfunction

  function automatic logic [NR-1:0] exp_fetch();
    logic [NR-1:0] v;
    for (int r = 0; r < NR; r++)
      v[r] = !m_fl[r] && ((m_head[r] != m_tail[r]) || (m_hg[r] != m_tg[r]) || m_wake[r]);
    return v;
  endfunction

  task automatic post(int r, int idx, int cnt, bit gen, int region);
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = mkaddr(r, region);
    st_data  = {gen, CW'(cnt), IW'(idx)};
    @(negedge clk);
    st_valid = 1'b0;
    if (region == 5) begin
      int s;
      s = (idx & msk(r)) + cnt;
      m_tail[r] = s & msk(r);
      m_tg[r]   = gen ^ ((s >> m_log[r]) & 1);
      if (cnt == 0) m_wake[r] = 1'b1;
    end
  endtask

  task automatic cmpl(int r);
    @(negedge clk);
    cmpl_valid = 1'b1;
    cmpl_ring  = 6'(r);
    @(negedge clk);
    cmpl_valid = 1'b0;
    if ((m_head[r] != m_tail[r]) || (m_hg[r] != m_tg[r])) begin
      if (m_head[r] == msk(r)) m_hg[r] = ~m_hg[r];
      m_head[r] = (m_head[r] + 1) & msk(r);
      m_cnt[r]  = (m_cnt[r] + 1) & 16'hffff;
    end
    m_wake[r] = 1'b0;
  endtask

  task automatic cfg(int r, int lg);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_ring = 6'(r); cfg_log2 = LW'(lg);
    @(negedge clk);
    cfg_valid = 1'b0;
    m_log[r] = lg;
  endtask

  task automatic flush(int r, bit v);
    @(negedge clk);
    flush_valid = 1'b1; flush_ring = 6'(r); flush_val = v;
    @(negedge clk);
    flush_valid = 1'b0;
    if (m_fl[r] && !v) m_cnt[r] = 0;
    m_fl[r] = v;
  endtask

  task automatic load_chk(int r, int region, string tag);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_addr  = mkaddr(r, region);
    @(negedge clk);
    ld_valid = 1'b0;
    if (region == 5) begin
      check({tag, " resp_valid"}, 64'(ld_resp_valid), 64'(1));
      check({tag, " data"}, 64'(ld_resp_data),
            64'({m_hg[r], CW'(m_cnt[r]), IW'(m_head[r])}));
    end else begin
      check({tag, " no response"}, 64'(ld_resp_valid), 64'(0));
    end
  endtask

  task automatic check_fetch(string tag);
    check({tag, " fetch_req"}, 64'(fetch_req), 64'(exp_fetch()));
  endtask

  task automatic drain(int r, int exp_n, string tag);
    int n = 0;
    while (fetch_req[r] && n < 40) begin
      cmpl(r);
      n++;
    end
    check({tag, " completions"}, 64'(n), 64'(exp_n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_head[r] = 0; m_tail[r] = 0; m_cnt[r] = 0; m_log[r] = 4;
      m_hg[r] = 0; m_tg[r] = 0; m_wake[r] = 0; m_fl[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_fetch("R1 reset");
    load_chk(0, 5, "R1 ring0");
    load_chk(63, 5, "R1 ring63");

    // R10 / R7: default size 16, post across the wrap point
    post(0, 14, 4, 1'b0, 5);
    check_fetch("R10 wrap post");
    drain(0, 18, "R10 wrap drain");
    load_chk(0, 5, "R7 gen after wrap");

    // R9: index bits above the ring size are ignored
    cfg(2, 3);
    post(2, 'h405, 2, 1'b0, 5);
    check_fetch("R9 masked idx");
    drain(2, 7, "R9 masked drain");
    load_chk(2, 5, "R9 head");

    // R3: foreign region store and load
    post(3, 0, 3, 1'b0, 4);
    check_fetch("R3 foreign store");
    load_chk(3, 6, "R3 foreign load");
    load_chk(3, 5, "R3 ring3 untouched");

    // R11: two rings pending at once, drained independently
    post(2, m_tail[2], 3, m_tg[2], 5);
    post(3, 0, 2, 1'b0, 5);
    check_fetch("R11 two rings");
    drain(3, 2, "R11 ring3");
    check_fetch("R11 ring2 still pending");
    drain(2, 3, "R11 ring2");
    load_chk(2, 5, "R11 ring2 state");

    // R8: flush suppresses fetch and clearing it zeroes the count
    post(3, m_tail[3], 2, m_tg[3], 5);
    cmpl(3);
    flush(3, 1'b1);
    check_fetch("R8 flushed");
    flush(3, 1'b0);
    load_chk(3, 5, "R8 count cleared");
    check_fetch("R8 resumed");
    drain(3, 1, "R8 rest");

    // R5: zero-count wake-up, empty completion leaves the head alone
    post(3, m_tail[3], 0, m_tg[3], 5);
    check_fetch("R5 wake");
    cmpl(3);
    check_fetch("R5 wake cleared");
    load_chk(3, 5, "R5 head unchanged");

    // R2 / R4 / R6 / R7: sweep sizes 2..8 and all counts 0..size on ring 1
    for (int lg = 1; lg <= 3; lg++) begin
      cfg(1, lg);
      for (int c = 0; c <= (1 << lg); c++) begin
        for (int rep = 0; rep < 2; rep++) begin
          post(1, m_tail[1], c, m_tg[1], 5);
          check_fetch("R2 sweep post");
          drain(1, (c == 0) ? 1 : c, "R4 sweep drain");
          load_chk(1, 5, "R6 sweep readback");
        end
      end
    end
    check_fetch("R11 final");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule